// File: doc/BRIEF.md
# Paired Word Load/Store Sequencer

This unit sits beside the load/store pipe of a 32-bit core. It carries out the 64-bit load and store forms as two ordered 32-bit accesses on a simple memory port. The issue stage hands it the raw instruction word and the value of the base register. The unit decodes the word and forms the effective address. It then runs the low word and the high word in turn, and ends with a single one-cycle status pulse: done, fault or illegal.

A load gathers both words into a holding buffer. It writes them to an even/odd register pair in one write cycle, and only when neither read faulted. A store reads the even register first and the odd register second, and writes them to consecutive words. A store that faults on its second word has still written its first.

The states are IDLE, ACC_LO, ACC_HI, WRITEBACK, DONE, FAULT and ILLEGAL. The transitions are as follows:
- An accepted request moves IDLE to ACC_LO. If the instruction is unusable, it moves IDLE to ILLEGAL instead.
- An acknowledged access with no error moves ACC_LO to ACC_HI. An error on that acknowledge moves ACC_LO to FAULT.
- In ACC_HI, an acknowledge with no error leads to WRITEBACK for a load and to DONE for a store. An error leads to FAULT.
- WRITEBACK moves to DONE.
- DONE, FAULT and ILLEGAL each return to IDLE.

Top module: `pairmem_seq`

## Requirements
- R1: A word is accepted as a paired load when bits [6:0] are 0000011 and bits [14:12] are 011. Its register index is in bits [11:7] and its offset is in bits [31:20]. A word is accepted as a paired store when bits [6:0] are 0100011 and bits [14:12] are 011. Its register index is in bits [24:20] and its offset is {bits[31:25], bits[11:7]}. Any other word ends in an illegal pulse with no memory access. When the XLEN parameter is not 32, every word ends in an illegal pulse.
- R2: The effective address is issue_base plus the 12-bit offset, sign-extended.
- R3: The first access goes to the effective address and the second to the effective address plus 4. mem_req, mem_addr and mem_we hold steady until mem_ack.
- R4: After two error-free reads, a load raises rf_we for exactly one cycle. In that cycle rf_widx is the even index and rf_wdata is {second word, first word}.
- R5: An error on the first access stops the operation. No second access is issued, the registers are not written, and fault pulses.
- R6: An error on the second read of a load leaves the registers unwritten and pulses fault.
- R7: A store writes the even register's value to the first word and the odd register's value to the second word. An error on the second write still pulses fault.
- R8: An odd register index pulses illegal with no memory access and no register write.
- R9: A load whose index is 0 completes with done and writes nothing. A store whose index is 0 writes zero to both words.
- R10: busy is high from the cycle after acceptance through the single status pulse, and low in the following cycle. Exactly one of done, fault or illegal pulses per operation. issue_valid is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| issue_valid | input | 1 | Request present; taken when the unit is idle |
| issue_instr | input | 32 | Raw instruction word |
| issue_base | input | XLEN | Value of the base register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle memory error pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| mem_req | output | 1 | Word access request, held until ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, sampled with ack |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | XLEN | Register file read data (combinational) |
| rf_we | output | 1 | Pair write strobe |
| rf_widx | output | 5 | Even index of the pair written |
| rf_wdata | output | 2*XLEN | {odd register, even register} |

## Verification
The bench checks error injection on each of the two accesses separately. A design that wrote the low register early would corrupt the pair after a second-read fault. A design that did not abort would issue a second access after a first-word error. The bench also uses a negative offset, odd indices, a wrong funct3 and the x0 pair in both directions. These catch unsigned offset handling, a missing illegal path and a store of a nonzero odd register. A second request held high through a long-latency operation shows whether the unit wrongly starts a new operation while busy.

// File: rtl/pairmem_pkg.sv
package pairmem_pkg;
    localparam int          INSTR_W   = 32;
    localparam int          RIDX_W    = 5;
    localparam int          OFFS_W    = 12;
    localparam logic [6:0]  OPC_LOAD  = 7'b0000011;
    localparam logic [6:0]  OPC_STORE = 7'b0100011;
    localparam logic [2:0]  F3_PAIR   = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC_LO,
        ST_ACC_HI,
        ST_WRITEBACK,
        ST_DONE,
        ST_FAULT,
        ST_ILLEGAL
    } seq_state_e;

    typedef struct packed {
        logic              is_store;
        logic [RIDX_W-1:0] ridx;
        logic [OFFS_W-1:0] offs;
        logic              bad;
    } pair_op_t;
endpackage

// File: rtl/pairmem_decode.sv
module pairmem_decode
    import pairmem_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output pair_op_t           op
);
    localparam bit WIDTH_OK = (XLEN == 32);

    logic is_ld;
    logic is_st;

    always_comb begin
        is_ld = (instr[6:0] == OPC_LOAD)  && (instr[14:12] == F3_PAIR);
        is_st = (instr[6:0] == OPC_STORE) && (instr[14:12] == F3_PAIR);

        op.is_store = is_st;
        op.ridx     = is_st ? instr[24:20] : instr[11:7];
        op.offs     = is_st ? {instr[31:25], instr[11:7]} : instr[31:20];
        // An odd index cannot name an even/odd pair.
        op.bad      = !WIDTH_OK || !(is_ld || is_st) || op.ridx[0];
    end
endmodule

// File: rtl/pairmem_agen.sv
module pairmem_agen #(
    parameter int XLEN   = 32,
    parameter int OFFS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [XLEN-1:0]   base,
    input  logic [OFFS_W-1:0] offs,
    output logic [XLEN-1:0]   addr_lo,
    output logic [XLEN-1:0]   addr_hi
);
    localparam int          WORD_BYTES = XLEN / 8;
    localparam int          EXT_W      = XLEN - OFFS_W;
    localparam logic [XLEN-1:0] STEP   = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] ea_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q <= '0;
        end else if (capture) begin
            ea_q <= base + {{EXT_W{offs[OFFS_W-1]}}, offs};
        end
    end

    assign addr_lo = ea_q;
    assign addr_hi = ea_q + STEP;
endmodule

// File: rtl/pairmem_rdbuf.sv
module pairmem_rdbuf #(
    parameter int XLEN  = 32,
    parameter int WORDS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORDS-1:0]      cap,
    input  logic [XLEN-1:0]       rdata,
    output logic [WORDS*XLEN-1:0] pair
);
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [XLEN-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (cap[g]) begin
                word_q <= rdata;
            end
        end
        assign pair[g*XLEN +: XLEN] = word_q;
    end
endmodule

// File: rtl/pairmem_seq.sv
module pairmem_seq
    import pairmem_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_valid,
    input  logic [INSTR_W-1:0]    issue_instr,
    input  logic [XLEN-1:0]       issue_base,
    output logic                  busy,
    output logic                  done,
    output logic                  fault,
    output logic                  illegal,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [XLEN-1:0]       mem_addr,
    output logic [XLEN-1:0]       mem_wdata,
    input  logic [XLEN-1:0]       mem_rdata,
    input  logic                  mem_ack,
    input  logic                  mem_err,
    output logic [RIDX_W-1:0]     rf_raddr,
    input  logic [XLEN-1:0]       rf_rdata,
    output logic                  rf_we,
    output logic [RIDX_W-1:0]     rf_widx,
    output logic [2*XLEN-1:0]     rf_wdata
);
    seq_state_e state_q, state_d;
    pair_op_t   dec_op, op_q;
    logic       accept;
    logic       ok_ack;
    logic [XLEN-1:0] addr_lo, addr_hi;
    logic [1:0]      cap;
    logic            ridx_zero;

    pairmem_decode #(.XLEN(XLEN)) u_dec (
        .instr (issue_instr),
        .op    (dec_op)
    );

    assign accept = (state_q == ST_IDLE) && issue_valid;
    assign ok_ack = mem_ack && !mem_err;

    pairmem_agen #(.XLEN(XLEN), .OFFS_W(OFFS_W)) u_agen (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .base    (issue_base),
        .offs    (dec_op.offs),
        .addr_lo (addr_lo),
        .addr_hi (addr_hi)
    );

    assign cap[0] = (state_q == ST_ACC_LO) && ok_ack && !op_q.is_store;
    assign cap[1] = (state_q == ST_ACC_HI) && ok_ack && !op_q.is_store;

    pairmem_rdbuf #(.XLEN(XLEN), .WORDS(2)) u_rdbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .rdata (mem_rdata),
        .pair  (rf_wdata)
    );

    // Latched request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (accept) begin
            op_q <= dec_op;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = dec_op.bad ? ST_ILLEGAL : ST_ACC_LO;
                end
            end
            ST_ACC_LO: begin
                if (mem_ack) begin
                    state_d = mem_err ? ST_FAULT : ST_ACC_HI;
                end
            end
            ST_ACC_HI: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        state_d = ST_FAULT;
                    end else begin
                        state_d = op_q.is_store ? ST_DONE : ST_WRITEBACK;
                    end
                end
            end
            ST_WRITEBACK: state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
            ST_ILLEGAL:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign ridx_zero = (op_q.ridx == '0);

    // Outputs
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        fault     = 1'b0;
        illegal   = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = addr_lo;
        rf_we     = 1'b0;
        rf_raddr  = {op_q.ridx[RIDX_W-1:1], 1'b0};
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_ACC_LO:    mem_req = 1'b1;
            ST_ACC_HI: begin
                mem_req  = 1'b1;
                mem_addr = addr_hi;
                rf_raddr = {op_q.ridx[RIDX_W-1:1], 1'b1};
            end
            ST_WRITEBACK: rf_we = !ridx_zero;
            ST_DONE:      done = 1'b1;
            ST_FAULT:     fault = 1'b1;
            ST_ILLEGAL:   illegal = 1'b1;
            default:      busy = 1'b0;
        endcase
        mem_we    = mem_req && op_q.is_store;
        mem_wdata = (mem_we && !ridx_zero) ? rf_rdata : '0;
        rf_widx   = op_q.ridx;
    end
endmodule

// File: rtl/pairmem_seq_chk.sv
module pairmem_seq_chk
    import pairmem_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            fault,
    input logic            illegal,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_ack,
    input logic            mem_err,
    input logic            rf_we,
    input seq_state_e      state_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC_HI) && ($past(state_q) == ST_ACC_LO) |-> mem_addr == $past(mem_addr) + STEP); // R3

    AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> fault && !mem_req && !rf_we); // R5

    AST_WB_AFTER_CLEAN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_req && mem_ack && !mem_err && !mem_we)); // R4

    AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req && !$past(busy)); // R8

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, illegal})); // R10

    AST_STATUS_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault || illegal) |=> !busy); // R10
endmodule

bind pairmem_seq pairmem_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .illegal  (illegal),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .rf_we    (rf_we),
    .state_q  (state_q)
);

// File: tb/tb_pairmem_seq.sv
module tb_pairmem_seq;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic [31:0]       issue_instr = '0;
    logic [XLEN-1:0]   issue_base = '0;
    logic              busy, done, fault, illegal;
    logic              mem_req, mem_we;
    logic [XLEN-1:0]   mem_addr, mem_wdata;
    logic [XLEN-1:0]   mem_rdata = '0;
    logic              mem_ack = 1'b0;
    logic              mem_err = 1'b0;
    logic [4:0]        rf_raddr;
    logic [XLEN-1:0]   rf_rdata;
    logic              rf_we;
    logic [4:0]        rf_widx;
    logic [2*XLEN-1:0] rf_wdata;

    logic [31:0] regs [32];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    pairmem_seq #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_instr(issue_instr), .issue_base(issue_base),
        .busy(busy), .done(done), .fault(fault), .illegal(illegal),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
    );

    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [31:0] enc_ld(input logic [4:0] rd, input logic [11:0] imm);
        return {imm, 5'd3, 3'b011, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_st(input logic [4:0] rs, input logic [11:0] imm);
        return {imm[11:5], rs, 5'd3, 3'b011, imm[4:0], 7'b0100011};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural model of one operation, compared every clock.
    task automatic run_op(input logic [31:0] instr, input logic [31:0] base, input int lat,
                          input int err_at, input bit poke, input string req);
        logic        is_ld, is_st, legal, exp_wb;
        logic [4:0]  idx;
        logic [11:0] imm;
        logic [31:0] ea;
        logic [31:0] exp_wd [2];
        logic [63:0] exp_pair;
        int          n_exp, n, wait_c, exp_stat, got_stat;
        bit          got_wb, finished;

        is_ld = (instr[6:0] == 7'b0000011) && (instr[14:12] == 3'b011);
        is_st = (instr[6:0] == 7'b0100011) && (instr[14:12] == 3'b011);
        idx   = is_st ? instr[24:20] : instr[11:7];
        imm   = is_st ? {instr[31:25], instr[11:7]} : instr[31:20];
        legal = (is_ld || is_st) && !idx[0];
        ea    = base + {{20{imm[11]}}, imm};
        n_exp = !legal ? 0 : (err_at == 1 ? 1 : 2);
        for (int k = 0; k < 2; k++) exp_wd[k] = (idx == 0) ? 32'h0 : regs[idx + 5'(k)];
        exp_wb   = legal && is_ld && err_at == 0 && idx != 0;
        exp_pair = {memword(ea + 32'd4), memword(ea)};
        exp_stat = !legal ? 2 : (err_at != 0 ? 1 : 0);

        @(negedge clk);
        issue_valid = 1'b1; issue_instr = instr; issue_base = base;
        @(negedge clk);
        issue_valid = poke;
        if (poke) begin issue_instr = enc_ld(5'd20, 12'h100); issue_base = 32'h7000; end

        n = 0; wait_c = 0; got_wb = 0; finished = 0; got_stat = -1;
        for (int cyc = 0; cyc < 80 && !finished; cyc++) begin
            check(busy == 1'b1, "R10", "busy during operation", 64'(busy), 64'd1);
            if (mem_req) begin
                check(n < n_exp, req, "access count", 64'(n), 64'(n_exp));
                if (n < n_exp) begin
                    check(mem_addr == ea + 32'(4 * n), "R3", "access address", 64'(mem_addr), 64'(ea + 32'(4 * n)));
                    check(mem_we == is_st, req, "access direction", 64'(mem_we), 64'(is_st));
                    if (is_st)
                        check(mem_wdata == exp_wd[n], "R7", "store word", 64'(mem_wdata), 64'(exp_wd[n]));
                end
                if (wait_c >= lat) begin
                    mem_ack = 1'b1;
                    mem_err = (n + 1 == err_at);
                    mem_rdata = memword(mem_addr);
                    n++; wait_c = 0;
                end else begin
                    wait_c++;
                end
            end
            if (rf_we) begin
                check(exp_wb, req, "unexpected register write", 64'(rf_we), 64'(exp_wb));
                check(rf_widx == idx, "R4", "write index", 64'(rf_widx), 64'(idx));
                check(rf_wdata == exp_pair, "R4", "write pair", rf_wdata, exp_pair);
                got_wb = 1;
            end
            if (done || fault || illegal) begin
                got_stat = done ? 0 : (fault ? 1 : 2);
                check(got_stat == exp_stat, req, "status (0 done,1 fault,2 illegal)", 64'(got_stat), 64'(exp_stat));
                finished = 1;
            end
            @(negedge clk);
            mem_ack = 1'b0; mem_err = 1'b0;
        end
        issue_valid = 1'b0;
        check(finished, "R10", "status pulse seen", 64'(finished), 64'd1);
        check(n == n_exp, req, "accesses issued", 64'(n), 64'(n_exp));
        check(got_wb == exp_wb, req, "register write seen", 64'(got_wb), 64'(exp_wb));
        check(busy == 1'b0, "R10", "busy after status", 64'(busy), 64'd0);
        if (exp_wb) begin
            regs[idx] = exp_pair[31:0];
            regs[idx + 5'd1] = exp_pair[63:32];
        end
        if (poke) begin
            repeat (2) @(negedge clk);
            check(!mem_req && !busy, "R10", "request while busy ignored", 64'({mem_req, busy}), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'h0 : (32'h0101_0101 * i) ^ 32'hC0DE_0000;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !rf_we && !done && !fault && !illegal, "R10", "reset outputs",
              64'({busy, mem_req, rf_we, done, fault, illegal}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(enc_ld(5'd4, 12'h010), 32'h0000_1000, 0, 0, 0, "R1");   // R1 R4 basic load
        run_op(enc_ld(5'd6, 12'hFF8), 32'h0000_2000, 2, 0, 0, "R2");   // R2 negative offset
        run_op(enc_st(5'd4, 12'h020), 32'h0000_3000, 1, 0, 0, "R7");   // R7 store the loaded pair
        run_op(enc_st(5'd10, 12'h804), 32'h0001_0000, 0, 0, 0, "R2");  // R2 store, most negative range
        run_op(enc_ld(5'd8, 12'h040), 32'h0000_4000, 1, 1, 0, "R5");   // R5 load fault on first
        run_op(enc_ld(5'd10, 12'h044), 32'h0000_4000, 0, 2, 0, "R6");  // R6 load fault on second
        run_op(enc_st(5'd12, 12'h050), 32'h0000_5000, 2, 2, 0, "R7");  // R7 store fault on second
        run_op(enc_st(5'd14, 12'h058), 32'h0000_5000, 0, 1, 0, "R5");  // R5 store fault on first
        run_op(enc_ld(5'd5, 12'h000), 32'h0000_6000, 0, 0, 0, "R8");   // R8 odd load index
        run_op(enc_st(5'd7, 12'h000), 32'h0000_6000, 0, 0, 0, "R8");   // R8 odd store index
        run_op(enc_ld(5'd0, 12'h060), 32'h0000_6100, 0, 0, 0, "R9");   // R9 load to x0 pair
        run_op(enc_st(5'd0, 12'h068), 32'h0000_6100, 1, 0, 0, "R9");   // R9 store x0 pair zeros
        run_op(enc_ld(5'd4, 12'h010) ^ 32'h0000_1000, 32'h1000, 0, 0, 0, "R1"); // R1 funct3 010
        run_op(32'h0000_3013, 32'h1000, 0, 0, 0, "R1");                // R1 other opcode
        run_op(enc_ld(5'd16, 12'h070), 32'h0000_8000, 3, 0, 1, "R10"); // R10 issue held high
        run_op(enc_st(5'd16, 12'h0F0), 32'h0000_8000, 0, 0, 0, "R7");  // R7 pair from previous load

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule